// File: doc/BRIEF.md
# Latency-Insensitive Operand Equalizer

This block sits in front of a synchronous core that consumes one operand from each of several input channels per firing. Each channel carries an event as a data word plus a one-bit tag. A tag of 1 means the event is real and a tag of 0 means the slot is empty. A single stall input comes from the consumer side. The block hands the core a complete operand set only when every channel has a real event and the consumer is not stalling. In every other cycle it hands the core empty events on all lanes.

Each channel has a one-entry hold register. An event that arrives before its partners waits in that register. The producer of that channel receives a stall, so it sends nothing new. Producers whose events are still missing receive no stall. When the consumer stalls, all producers are stalled, and no held event is released or dropped. All outputs are registered, so results appear one clock after the inputs that cause them.

Top module: `li_equalizer`

## Requirements
- R1: A synchronous active-high reset clears every hold register. On the cycle after reset, all `out_valid` bits, all `out_data` bits and all `up_stall` bits are 0.
- R2: If `dn_stall` is 1 at a clock edge, then after that edge `out_valid` is all zeros and `up_stall` is all ones.
- R3: If `dn_stall` is 0 at an edge and every channel has a real event (held or offered), then after that edge `out_valid` is all ones and `up_stall` is all zeros. Lane i of `out_data` (bits i*DATA_W upward) carries that channel's event unchanged.
- R4: If `dn_stall` is 0 at an edge and at least one channel has no event, then after that edge `out_valid` is all zeros. `up_stall[i]` is 1 exactly for the channels that hold or are offering a real event, and 0 for the others.
- R5: An event received while its set is incomplete is kept, not consumed. It is forwarded in the cycle in which the set completes.
- R6: While a channel's hold register is occupied, a new event offered on that channel is ignored. The held value is the one forwarded.
- R7: While `dn_stall` is 1, no held event is released or lost. An event offered to an empty channel is captured. Once `dn_stall` falls, a complete set fires with the captured values.
- R8: A firing empties every hold register. A following cycle with no offers yields all-zero `out_valid` and `up_stall`.
- R9: Whenever `out_valid` is all zeros, `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | NUM_IN | Per-channel tag, 1 = real event |
| in_data | input | NUM_IN*DATA_W | Per-channel data, lane i at bits i*DATA_W upward |
| dn_stall | input | 1 | Consumer-side stall |
| out_valid | output | NUM_IN | Per-lane tag toward the core |
| out_data | output | NUM_IN*DATA_W | Operand lanes toward the core |
| up_stall | output | NUM_IN | Per-channel stall toward the producers |

## Verification
Every result of this block comes from one register stage. The values driven before edge k therefore appear on `out_valid`, `out_data` and `up_stall` right after edge k and stay there until edge k+1. The bench changes inputs on the falling edge and compares outputs on the next falling edge, which is exactly one rising edge later. A held event is checked by observing when it emerges on the lanes several such steps later. Those expected lane values are worked out by hand from the sequence of offers and stalls.

// File: rtl/li_eq_pkg.sv
package li_eq_pkg;
    typedef enum logic [1:0] {
        MODE_DISABLE,
        MODE_ABSENT,
        MODE_PRESENT
    } eq_mode_e;
endpackage

// File: rtl/li_eq_slot.sv
// One channel's hold register: keeps a real event until the set fires.
module li_eq_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_v,
    input  logic [DATA_W-1:0] take_d,
    input  logic              release_i,
    output logic              eff_v,
    output logic [DATA_W-1:0] eff_d
);
    typedef struct packed {
        logic              occ;
        logic [DATA_W-1:0] dat;
    } slot_s;

    slot_s slot_d, slot_q;

    always_comb begin
        eff_v  = slot_q.occ | take_v;
        eff_d  = slot_q.occ ? slot_q.dat : take_d;
        slot_d = slot_q;
        if (release_i) begin
            slot_d.occ = 1'b0;
            slot_d.dat = '0;
        end else if (!slot_q.occ && take_v) begin
            slot_d.occ = 1'b1;
            slot_d.dat = take_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end
endmodule

// File: rtl/li_eq_mode.sv
// Picks disable / absent / present for the current cycle.
module li_eq_mode
    import li_eq_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic              dn_stall,
    input  logic [NUM_IN-1:0] present,
    output eq_mode_e          mode
);
    always_comb begin
        if (dn_stall)      mode = MODE_DISABLE;
        else if (&present) mode = MODE_PRESENT;
        else               mode = MODE_ABSENT;
    end
endmodule

// File: rtl/li_equalizer.sv
module li_equalizer
    import li_eq_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_IN-1:0]        in_valid,
    input  logic [NUM_IN*DATA_W-1:0] in_data,
    input  logic                     dn_stall,
    output logic [NUM_IN-1:0]        out_valid,
    output logic [NUM_IN*DATA_W-1:0] out_data,
    output logic [NUM_IN-1:0]        up_stall
);
    localparam int BUS_W = NUM_IN * DATA_W;

    typedef struct packed {
        logic [NUM_IN-1:0] vld;
        logic [BUS_W-1:0]  dat;
        logic [NUM_IN-1:0] stl;
    } out_s;

    logic [NUM_IN-1:0] present;
    logic [BUS_W-1:0]  eff_data;
    eq_mode_e          mode;
    logic              fire;
    out_s              out_d, out_q;

    for (genvar g = 0; g < NUM_IN; g++) begin : g_slot
        li_eq_slot #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .take_v    (in_valid[g]),
            .take_d    (in_data[g*DATA_W +: DATA_W]),
            .release_i (fire),
            .eff_v     (present[g]),
            .eff_d     (eff_data[g*DATA_W +: DATA_W])
        );
    end

    li_eq_mode #(.NUM_IN(NUM_IN)) u_mode (
        .dn_stall (dn_stall),
        .present  (present),
        .mode     (mode)
    );

    assign fire = (mode == MODE_PRESENT);

    always_comb begin
        out_d = '0;
        unique case (mode)
            MODE_DISABLE: out_d.stl = '1;
            MODE_ABSENT:  out_d.stl = present;
            MODE_PRESENT: begin
                out_d.vld = '1;
                out_d.dat = eff_data;
            end
            default:      out_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign out_data  = out_q.dat;
    assign up_stall  = out_q.stl;
endmodule

// File: rtl/li_equalizer_chk.sv
module li_equalizer_chk #(
    parameter int NUM_IN = 4,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_IN-1:0]        in_valid,
    input logic [NUM_IN*DATA_W-1:0] in_data,
    input logic                     dn_stall,
    input logic [NUM_IN-1:0]        out_valid,
    input logic [NUM_IN*DATA_W-1:0] out_data,
    input logic [NUM_IN-1:0]        up_stall
);
    logic unused_data;
    assign unused_data = ^in_data;

    AST_DISABLE_STALLS_ALL: assert property (@(posedge clk) disable iff (rst)
        (!rst && dn_stall) |=> (&up_stall && out_valid == '0)); // R2

    AST_LANES_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid == '0) || (&out_valid)); // R3

    AST_FIRE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> (up_stall == '0)); // R3

    AST_OFFER_HELD_OR_FIRED: assert property (@(posedge clk) disable iff (rst)
        (!rst && !dn_stall) |=>
            (((out_valid | up_stall) & $past(in_valid)) == $past(in_valid))); // R4

    AST_ABSENT_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid == '0) |-> (out_data == '0)); // R9
endmodule

bind li_equalizer li_equalizer_chk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .dn_stall  (dn_stall),
    .out_valid (out_valid),
    .out_data  (out_data),
    .up_stall  (up_stall)
);

// File: tb/test_li_equalizer.sv
`timescale 1ns/1ps
module test_li_equalizer;
    localparam int NI = 4;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NI-1:0]    in_valid = '0;
    logic [NI*DW-1:0] in_data = '0;
    logic             dn_stall = 1'b0;
    logic [NI-1:0]    out_valid;
    logic [NI*DW-1:0] out_data;
    logic [NI-1:0]    up_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    li_equalizer #(.NUM_IN(NI), .DATA_W(DW)) i_li_equalizer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .dn_stall(dn_stall), .out_valid(out_valid), .out_data(out_data),
        .up_stall(up_stall)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge; return at the next falling edge (one rising edge later).
    task automatic step(input logic [NI-1:0] v, input logic [NI*DW-1:0] d, input logic s);
        in_valid = v;
        in_data  = d;
        dn_stall = s;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [NI-1:0] v,
                              input logic [NI*DW-1:0] d, input logic [NI-1:0] s);
        chk({tag, " out_valid"}, 64'(out_valid), 64'(v));
        chk({tag, " out_data"},  64'(out_data),  64'(d));
        chk({tag, " up_stall"},  64'(up_stall),  64'(s));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_out("R1 reset", '0, '0, '0);
        step('0, '0, 1'b0);
        expect_out("R1 idle after reset", '0, '0, '0);
    endtask

    task automatic t_full_set;
        step(4'hF, 32'h44332211, 1'b0);
        expect_out("R3 full set", 4'hF, 32'h44332211, 4'h0);
        step('0, '0, 1'b0);
        expect_out("R8 R9 empty after fire", 4'h0, '0, 4'h0);
    endtask

    task automatic t_partial;
        step(4'b0101, 32'h00C200A0, 1'b0);
        expect_out("R4 R9 partial 0101", 4'h0, '0, 4'b0101);
        step(4'b0010, 32'h0000B100, 1'b0);
        expect_out("R4 partial 0111", 4'h0, '0, 4'b0111);
        // lanes 0 and 2 re-offered with other data: must be ignored
        step(4'b1101, 32'hD3EE00EE, 1'b0);
        expect_out("R5 R6 completed set", 4'hF, 32'hD3C2B1A0, 4'h0);
        step('0, '0, 1'b0);
        expect_out("R8 after partial fire", 4'h0, '0, 4'h0);
    endtask

    task automatic t_disable_capture;
        step(4'b0011, 32'h00005A4B, 1'b1);
        expect_out("R2 disable first", 4'h0, '0, 4'hF);
        step(4'b1100, 32'h7C6D0000, 1'b1);
        expect_out("R2 R7 disable second", 4'h0, '0, 4'hF);
        step('0, '0, 1'b0);
        expect_out("R7 release after stall", 4'hF, 32'h7C6D5A4B, 4'h0);
        step('0, '0, 1'b0);
        expect_out("R8 after stall fire", 4'h0, '0, 4'h0);
    endtask

    task automatic t_disable_full;
        step(4'hF, 32'h81828384, 1'b1);
        expect_out("R2 full set stalled", 4'h0, '0, 4'hF);
        step(4'hF, 32'h11111111, 1'b1);
        expect_out("R6 R7 held under stall", 4'h0, '0, 4'hF);
        step('0, '0, 1'b0);
        expect_out("R7 stalled set fires", 4'hF, 32'h81828384, 4'h0);
        step('0, '0, 1'b0);
        expect_out("R8 final idle", 4'h0, '0, 4'h0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_full_set();
        t_partial();
        t_disable_capture();
        t_disable_full();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule